// File: doc/BRIEF.md
# Shared GPIO Port Controller

An eight-bit general-purpose pin port. A small synchronous register bus gives software access to four per-pin control banks: output data, output-driver direction, pullup request and slew-rate request. From these banks the block drives, for each pin, an output value, an output enable, a pullup enable and a slew-control enable toward the pad ring. Pin levels coming back from the pads pass through a multi-flop synchronizer before software can read them.

Two on-chip serial peripherals, a UART and an SPI, can claim individual pins through per-pin ownership inputs. A claimed pin takes its drive enable and output value from the owning peripheral, and the direction bank is ignored for it. The pullup and slew banks keep acting on claimed pins, gated by the effective direction, so a pullup appears only on a pin that is not driving and slew control only on a pin that is.

Top module: `gpio_share_port`

## Requirements
- R1: While reset is asserted and right after it is released, the data, pullup, slew and direction banks read as zero, and pin_oe, pin_pull_en and pin_slew_en are all zero.
- R2: A write to bank select 0 (data) stores all eight bits whatever the direction. In the cycle after the write, a read of select 0 returns the stored bit for every pin whose direction bit is 1.
- R3: For every pin whose direction bit is 0, a read of select 0 returns the pin_in level. A change on pin_in shows up after exactly two rising clock edges, and not after one.
- R4: On a pin that no peripheral owns, pin_oe equals its direction bit and pin_out equals its data bit. Direction 1 means driving and 0 means high impedance.
- R5: pin_pull_en for a pin is 1 only when its pullup bit is 1, its direction bit is 0 and the pin is not driving (pin_oe 0). This also holds on peripheral-owned pins.
- R6: pin_slew_en for a pin is 1 only when its slew bit is 1 and the pin is driving (pin_oe 1). On a pin that is not driving, the slew bit has no effect.
- R7: When uart_own for a pin is 1, pin_oe follows uart_oe and pin_out follows uart_dout, whatever the direction bit holds.
- R8: When spi_own for a pin is 1 and uart_own is 0, pin_oe follows spi_oe and pin_out follows spi_dout, whatever the direction bit holds.
- R9: When uart_own and spi_own are both 1 for the same pin, the UART values win.
- R10: Bank selects are 0 data, 1 pullup, 2 slew and 3 direction. A write takes effect on the next rising edge. Reads of selects 1 to 3 are combinational and return the stored bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for the bank selected by bus_addr |
| bus_addr | input | 2 | Bank select for both reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for the selected bank |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Output value for each pad |
| pin_oe | output | 8 | Output driver enable for each pad |
| pin_pull_en | output | 8 | Pullup enable for each pad |
| pin_slew_en | output | 8 | Slew-rate control enable for each pad |
| uart_own | input | 8 | Per-pin UART ownership claim |
| uart_oe | input | 8 | UART drive request per pin |
| uart_dout | input | 8 | UART output value per pin |
| spi_own | input | 8 | Per-pin SPI ownership claim |
| spi_oe | input | 8 | SPI drive request per pin |
| spi_dout | input | 8 | SPI output value per pin |

## Verification
The pad outputs are combinational from the bank state and the ownership inputs, so the bench checks them in the same cycle as the ownership change, or in the cycle after the write edge that updates a bank. A register write shows up in read data one edge after the strobe. A pin_in change shows up in read data only after two edges, and the bench samples once after the first edge to confirm the old value still holds, then again after the second. Every sample falls in the low phase of the clock, one nanosecond after the inputs settle, well clear of the rising edge.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;

   localparam int unsigned SEL_W    = 2;
   localparam int unsigned NUM_BANK = 4;

   typedef enum logic [SEL_W-1:0] {
      BANK_DATA = 2'd0,
      BANK_PULL = 2'd1,
      BANK_SLEW = 2'd2,
      BANK_DIR  = 2'd3
   } bank_sel_e;

endpackage

// File: rtl/gpio_share_regs.sv
module gpio_share_regs
   import gpio_share_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] data_q,
   output logic [WIDTH-1:0] pull_q,
   output logic [WIDTH-1:0] slew_q,
   output logic [WIDTH-1:0] dir_q
);

   logic [NUM_BANK-1:0][WIDTH-1:0] bank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '0;
      end else begin
         for (int b = 0; b < NUM_BANK; b++) begin
            if (wr_en && (wr_sel == SEL_W'(b))) begin
               bank_q[b] <= wr_data;
            end
         end
      end
   end

   assign data_q = bank_q[BANK_DATA];
   assign pull_q = bank_q[BANK_PULL];
   assign slew_q = bank_q[BANK_SLEW];
   assign dir_q  = bank_q[BANK_DIR];

   // R10: a strobed write is visible in the selected bank after the edge
   p_wr_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (bank_q[$past(wr_sel)] == $past(wr_data)));

endmodule

// File: rtl/gpio_share_sync.sv
module gpio_share_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   localparam int unsigned AGE_W = $clog2(STAGES + 1);

   generate
      if (STAGES < 2 || STAGES > 8) begin : g_bad_stages
         $error("gpio_share_sync: STAGES must lie in 2..8");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= async_in;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_out = chain_q[STAGES-1];

   // Edge counter that saturates once the chain is fully primed.
   logic [AGE_W-1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age_q <= '0;
      end else if (age_q != AGE_W'(STAGES)) begin
         age_q <= age_q + 1'b1;
      end
   end

   // R3: the output trails the pad input by exactly STAGES edges
   p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == AGE_W'(STAGES)) |-> (sync_out == $past(async_in, STAGES)));

endmodule

// File: rtl/gpio_share_pinmux.sv
module gpio_share_pinmux #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] data_q,
   input  logic [WIDTH-1:0] pull_q,
   input  logic [WIDTH-1:0] slew_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] uart_own,
   input  logic [WIDTH-1:0] uart_oe,
   input  logic [WIDTH-1:0] uart_dout,
   input  logic [WIDTH-1:0] spi_own,
   input  logic [WIDTH-1:0] spi_oe,
   input  logic [WIDTH-1:0] spi_dout,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pin_pull_en,
   output logic [WIDTH-1:0] pin_slew_en
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic drive_en;
      logic drive_val;

      always_comb begin
         if (uart_own[i]) begin
            drive_en  = uart_oe[i];
            drive_val = uart_dout[i];
         end else if (spi_own[i]) begin
            drive_en  = spi_oe[i];
            drive_val = spi_dout[i];
         end else begin
            drive_en  = dir_q[i];
            drive_val = data_q[i];
         end
      end

      assign pin_oe[i]      = drive_en;
      assign pin_out[i]     = drive_val;
      assign pin_pull_en[i] = pull_q[i] & ~drive_en & ~dir_q[i];
      assign pin_slew_en[i] = slew_q[i] & drive_en;
   end

   // R5: no pullup on a driving pin
   always_comb begin
      p_pull_off_drv_r5: assert ((pin_pull_en & pin_oe) == '0);
   end

   // R6: no slew control on a pin that is not driving
   always_comb begin
      p_slew_off_in_r6: assert ((pin_slew_en & ~pin_oe) == '0);
   end

   // R7 / R9: a UART claim decides the drive, even against an SPI claim
   always_comb begin
      p_uart_wins_r9: assert ((uart_own & ((pin_oe ^ uart_oe) | (pin_out ^ uart_dout))) == '0);
   end

   // R8: an SPI claim decides the drive when the UART does not claim
   always_comb begin
      p_spi_drive_r8: assert ((spi_own & ~uart_own & ((pin_oe ^ spi_oe) | (pin_out ^ spi_dout))) == '0);
   end

endmodule

// File: rtl/gpio_share_port.sv
module gpio_share_port
   import gpio_share_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr_en,
   input  logic [1:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   input  logic [7:0]       pin_in,
   output logic [7:0]       pin_out,
   output logic [7:0]       pin_oe,
   output logic [7:0]       pin_pull_en,
   output logic [7:0]       pin_slew_en,
   input  logic [7:0]       uart_own,
   input  logic [7:0]       uart_oe,
   input  logic [7:0]       uart_dout,
   input  logic [7:0]       spi_own,
   input  logic [7:0]       spi_oe,
   input  logic [7:0]       spi_dout
);

   generate
      if (WIDTH != 8) begin : g_bad_width
         $error("gpio_share_port: WIDTH must match the 8-bit port list");
      end
   endgenerate

   logic [WIDTH-1:0] data_q, pull_q, slew_q, dir_q;
   logic [WIDTH-1:0] pin_sync;
   logic [WIDTH-1:0] data_view;

   gpio_share_regs #(.WIDTH(WIDTH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr_en),
      .wr_sel  (bus_addr),
      .wr_data (bus_wdata),
      .data_q  (data_q),
      .pull_q  (pull_q),
      .slew_q  (slew_q),
      .dir_q   (dir_q)
   );

   gpio_share_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (pin_sync)
   );

   gpio_share_pinmux #(.WIDTH(WIDTH)) u_pinmux (
      .data_q      (data_q),
      .pull_q      (pull_q),
      .slew_q      (slew_q),
      .dir_q       (dir_q),
      .uart_own    (uart_own),
      .uart_oe     (uart_oe),
      .uart_dout   (uart_dout),
      .spi_own     (spi_own),
      .spi_oe      (spi_oe),
      .spi_dout    (spi_dout),
      .pin_out     (pin_out),
      .pin_oe      (pin_oe),
      .pin_pull_en (pin_pull_en),
      .pin_slew_en (pin_slew_en)
   );

   // Data-bank view: stored bit on output pins, synchronized pad on inputs.
   assign data_view = (data_q & dir_q) | (pin_sync & ~dir_q);

   always_comb begin
      unique case (bank_sel_e'(bus_addr))
         BANK_DATA: bus_rdata = data_view;
         BANK_PULL: bus_rdata = pull_q;
         BANK_SLEW: bus_rdata = slew_q;
         BANK_DIR:  bus_rdata = dir_q;
         default:   bus_rdata = '0;
      endcase
   end

   // R2: output-direction bits of a data write read back on the next cycle
   p_out_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && bus_addr == BANK_DATA) |=>
         (((data_view ^ $past(bus_wdata)) & dir_q) == '0));

endmodule

// File: tb/gpio_share_port_tb.sv
module gpio_share_port_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr_en = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [7:0] pin_in = 8'h3C;
   logic [7:0] pin_out, pin_oe, pin_pull_en, pin_slew_en;
   logic [7:0] uart_own = 8'h00, uart_oe = 8'h00, uart_dout = 8'h00;
   logic [7:0] spi_own = 8'h00, spi_oe = 8'h00, spi_dout = 8'h00;

   always #2.5 clk = ~clk;

   gpio_share_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_pull_en(pin_pull_en),
      .pin_slew_en(pin_slew_en), .uart_own(uart_own), .uart_oe(uart_oe),
      .uart_dout(uart_dout), .spi_own(spi_own), .spi_oe(spi_oe), .spi_dout(spi_dout)
   );

   typedef enum int {K_RD, K_OE, K_OUT, K_PULL, K_SLEW} kind_e;
   typedef struct {
      kind_e      kind;
      logic [7:0] exp;
      string      req;
   } item_t;

   item_t q[$];
   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;

   // Bench model of the banks, updated from the writes it issues.
   logic [7:0] m_data = 0, m_pull = 0, m_slew = 0, m_dir = 0;

   function automatic logic [7:0] e_oe();
      return (uart_own & uart_oe) | (~uart_own & spi_own & spi_oe)
           | (~uart_own & ~spi_own & m_dir);
   endfunction
   function automatic logic [7:0] e_out();
      return (uart_own & uart_dout) | (~uart_own & spi_own & spi_dout)
           | (~uart_own & ~spi_own & m_data);
   endfunction

   // Monitor: compares queued expectations with the live outputs.
   initial begin
      forever begin
         wait (q.size() != 0);
         #1;
         while (q.size() != 0) begin
            item_t it;
            logic [7:0] act;
            it = q[0];
            case (it.kind)
               K_RD:    act = bus_rdata;
               K_OE:    act = pin_oe;
               K_OUT:   act = pin_out;
               K_PULL:  act = pin_pull_en;
               default: act = pin_slew_en;
            endcase
            checks++;
            if (act !== it.exp) begin
               fails++;
               $display("FAIL %s %s actual=%h expected=%h", it.req, it.kind.name(), act, it.exp);
            end
            void'(q.pop_front());
         end
      end
   end

   task automatic push(kind_e k, logic [7:0] e, string r);
      item_t it;
      it.kind = k; it.exp = e; it.req = r;
      q.push_back(it);
   endtask

   task automatic flush();
      wait (q.size() == 0);
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] v);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = a; bus_wdata = v;
      @(posedge clk);
      @(negedge clk);
      bus_wr_en = 1'b0;
      case (a)
         2'd0: m_data = v;
         2'd1: m_pull = v;
         2'd2: m_slew = v;
         default: m_dir = v;
      endcase
   endtask

   task automatic rd_check(logic [1:0] a, logic [7:0] e, string r);
      bus_addr = a;
      push(K_RD, e, r);
      flush();
   endtask

   task automatic pins_check(string r);
      logic [7:0] oe;
      oe = e_oe();
      push(K_OE, oe, r);
      push(K_OUT, e_out(), r);
      push(K_PULL, m_pull & ~oe & ~m_dir, r);
      push(K_SLEW, m_slew & oe, r);
      flush();
   endtask

   initial begin
      // R1: reset state, checked while reset is held and after release
      repeat (3) @(negedge clk);
      rd_check(2'd1, 8'h00, "R1");
      rd_check(2'd3, 8'h00, "R1");
      pins_check("R1");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      rd_check(2'd2, 8'h00, "R1");
      pins_check("R1");
      rd_check(2'd0, 8'h3C, "R3");

      // R2: data write with all pins as inputs still lands in the bank
      wr(2'd0, 8'hA5);
      rd_check(2'd0, 8'h3C, "R3");
      pins_check("R4");
      wr(2'd3, 8'h0F);
      rd_check(2'd0, 8'h35, "R2");
      pins_check("R4");
      wr(2'd0, 8'h5A);
      rd_check(2'd0, 8'h3A, "R2");

      // R10: bank selects read back what was written
      wr(2'd1, 8'hFF);
      wr(2'd2, 8'hFF);
      rd_check(2'd1, 8'hFF, "R10");
      rd_check(2'd2, 8'hFF, "R10");
      rd_check(2'd3, 8'h0F, "R10");
      pins_check("R5");
      pins_check("R6");

      // R3: two-edge latency on the pad input path
      @(negedge clk);
      pin_in = 8'hC3;
      @(negedge clk);
      rd_check(2'd0, 8'h3A, "R3");
      @(negedge clk);
      rd_check(2'd0, 8'hCA, "R3");

      // R7: UART claims pin 0 as input (direction bit 1 ignored) and pin 7 as output
      @(negedge clk);
      uart_own = 8'h81; uart_oe = 8'h80; uart_dout = 8'h80;
      pins_check("R7");
      wr(2'd3, 8'h0E);
      pins_check("R5");
      wr(2'd3, 8'h0F);

      // R8: SPI claims pins 4 and 5, drives pin 4 low, leaves pin 5 as input
      @(negedge clk);
      spi_own = 8'h30; spi_oe = 8'h10; spi_dout = 8'h00;
      pins_check("R8");
      spi_dout = 8'h10;
      pins_check("R8");

      // R9: both claim pin 4 and pin 1; UART values decide
      @(negedge clk);
      uart_own = 8'h93; uart_oe = 8'h82; uart_dout = 8'h00;
      spi_own = 8'h32; spi_oe = 8'h12; spi_dout = 8'h12;
      pins_check("R9");

      // R6: slew bank cleared on an owned output has no slew
      wr(2'd2, 8'h7F);
      pins_check("R6");

      // R1: reset again clears banks and pad controls
      @(negedge clk);
      uart_own = 0; spi_own = 0; rst_n = 1'b0;
      m_data = 0; m_pull = 0; m_slew = 0; m_dir = 0;
      @(negedge clk);
      rd_check(2'd3, 8'h00, "R1");
      pins_check("R1");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule